// File: doc/BRIEF.md
# Effective Address and Access Sequencer

This block sits between the operand decoder of a small 8-bit CPU and its memory bus. For each load or store it receives an addressing-mode code, one operand field (a displacement, an absolute address or an I/O offset), the current address-register and stack-pointer values, an access size and a direction. From these it forms a 16-bit effective address, and then runs the bus transfers that the access needs. At the end it returns the loaded value and the number of cycles the access took.

Displacements added to an address register are sign-extended. Short displacements added to the stack pointer are zero-extended. Absolute fields are zero-extended. I/O accesses are offsets from a base address fixed at build time. Words are stored least-significant byte first. A word at an even address moves in one 16-bit transfer. A word at an odd address is split into two byte transfers, and that split costs one extra cycle. The block also extends 8-bit immediates for register loads, and it rejects byte-immediate stores that use a mode other than I/O or absolute.

Top module: `addr_access_seq`

## Requirements
- R1: Mode codes for address-register addressing. Code 0 uses the address register itself as the address. Code 1 adds `req_field[7:0]`, sign-extended to 16 bits. Code 2 adds the full `req_field`. All sums wrap modulo 2^16.
- R2: Mode codes for stack-pointer addressing. Code 3 adds `req_field[3:0]`, zero-extended. Code 4 adds `req_field[7:0]`, zero-extended. Code 5 adds the full `req_field`. All sums wrap modulo 2^16.
- R3: Mode code 6 addresses `IO_BASE + req_field[7:0]`, where the offset is zero-extended and the sum wraps.
- R4: Absolute mode codes zero-extend the address field. Code 7 uses `req_field[7:0]`, code 8 uses `req_field[11:0]` and code 9 uses all 16 bits.
- R5: Mode code 10 returns `req_field[7:0]` sign-extended to 16 bits. Mode code 11 returns it zero-extended. Neither mode makes a bus transfer, and both report a count of 1.
- R6: A byte access makes exactly one transfer with `mem_word`=0, with data on lane [7:0]. An even-address word access makes exactly one transfer with `mem_word`=1. In that transfer, bits [7:0] belong at the address and bits [15:8] at the address plus one. Both kinds of access report a count of 2. A byte read returns zero in `rd_data[15:8]`.
- R7: An odd-address word access makes two consecutive byte transfers. The first moves the low byte at address A. The second moves the high byte at A+1, wrapping modulo 2^16. The access reports a count of 3, one more than an even-address word.
- R8: A request is illegal in any of these cases:
  - the mode code is 12 to 15;
  - the mode code is 10 or 11 and the request is a write or has an immediate source;
  - it has an immediate source and is not a byte write with mode code 6 to 9.
  An illegal request makes no bus transfer and completes with `err`=1 and a count of 1.
- R9: `done` is high for exactly one cycle per accepted request. That cycle comes `cycles` clock cycles after the accepting edge. No transfer happens in the `done` cycle. A `req_valid` seen while an access is in progress is ignored.
- R10: After reset, `done`, `err` and `mem_req` are low. `rd_data` is 0 for writes and for illegal requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start an access (taken when idle) |
| req_mode | input | 4 | Addressing-mode code |
| req_field | input | ADDR_W | Displacement, absolute, I/O offset or immediate field |
| areg_val | input | ADDR_W | Selected address-register value |
| sp_val | input | ADDR_W | Stack-pointer value |
| req_word | input | 1 | 1 = word access, 0 = byte |
| req_write | input | 1 | 1 = store, 0 = load |
| req_imm | input | 1 | Store source is an immediate |
| req_wdata | input | 16 | Store data |
| done | output | 1 | Completion pulse |
| err | output | 1 | Request was illegal (valid with done) |
| cycles | output | CNT_W | Cycles used (valid with done) |
| rd_data | output | 16 | Loaded or extended value (valid with done) |
| mem_req | output | 1 | Bus transfer this cycle |
| mem_we | output | 1 | Transfer is a write |
| mem_word | output | 1 | Transfer is a 16-bit aligned transfer |
| mem_addr | output | ADDR_W | Transfer address |
| mem_wdata | output | 16 | Write data (byte on [7:0]) |
| mem_rdata | input | 16 | Read data, valid in the transfer cycle |

## Verification
Two things can happen in the same cycle: a fresh `req_valid` can arrive while the sequencer is still busy, either in the middle of a split odd-word transfer or during the completion cycle of an illegal or immediate request. The bench provokes this by raising `req_valid` with different inputs on the first busy cycle of both directed and random accesses. It judges the outcome from the bus trace and the returned result, which must match the original request. It also checks that no transfer and no second `done` pulse follow in the next two cycles.

// File: rtl/eas_pkg.sv
// Shared constants and types for the effective-address sequencer.
// Assumes an 8-bit byte and a two-byte data word.
package eas_pkg;
    localparam int BYTE_W = 8;
    localparam int DATA_W = 2 * BYTE_W;

    // Addressing-mode codes; 12..15 are reserved and illegal.
    typedef enum logic [3:0] {
        AM_AREG     = 4'd0,
        AM_AREG_D8  = 4'd1,
        AM_AREG_D16 = 4'd2,
        AM_SP_D4    = 4'd3,
        AM_SP_D8    = 4'd4,
        AM_SP_D16   = 4'd5,
        AM_IO8      = 4'd6,
        AM_ABS8     = 4'd7,
        AM_ABS12    = 4'd8,
        AM_ABS16    = 4'd9,
        AM_IMM_SX   = 4'd10,
        AM_IMM_ZX   = 4'd11
    } amode_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_LO,
        ST_HI,
        ST_DONE
    } seq_st_e;
endpackage

// File: rtl/eas_ea_calc.sv
// Combinational effective-address former and legality check.
// Assumes ADDR_W >= 16; the I/O base is fixed at build time.
module eas_ea_calc
    import eas_pkg::*;
#(
    parameter int                 ADDR_W  = 16,
    parameter logic [ADDR_W-1:0]  IO_BASE = 'hFC00
) (
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] field,
    input  logic [ADDR_W-1:0] areg,
    input  logic [ADDR_W-1:0] sp,
    input  logic              is_word,
    input  logic              is_write,
    input  logic              imm_src,
    output logic [ADDR_W-1:0] ea,
    output logic              illegal,
    output logic              imm_load,
    output logic [DATA_W-1:0] imm_val
);
    localparam int PAD4  = ADDR_W - 4;
    localparam int PAD8  = ADDR_W - 8;
    localparam int PAD12 = ADDR_W - 12;
    localparam int DPAD  = DATA_W - BYTE_W;

    logic [ADDR_W-1:0] d4_zx, d8_zx, d8_sx, a12_zx;
    logic              reserved, imm_mode, imm_store_ok;

    // Field extensions used by the address sums.
    assign d4_zx  = {{PAD4{1'b0}}, field[3:0]};
    assign d8_zx  = {{PAD8{1'b0}}, field[7:0]};
    assign d8_sx  = {{PAD8{field[7]}}, field[7:0]};
    assign a12_zx = {{PAD12{1'b0}}, field[11:0]};

    // Select the base and offset per mode; sums wrap at ADDR_W bits.
    always_comb begin
        case (mode)
            AM_AREG:     ea = areg;
            AM_AREG_D8:  ea = areg + d8_sx;
            AM_AREG_D16: ea = areg + field;
            AM_SP_D4:    ea = sp + d4_zx;
            AM_SP_D8:    ea = sp + d8_zx;
            AM_SP_D16:   ea = sp + field;
            AM_IO8:      ea = IO_BASE + d8_zx;
            AM_ABS8:     ea = d8_zx;
            AM_ABS12:    ea = a12_zx;
            AM_ABS16:    ea = field;
            default:     ea = '0;
        endcase
    end

    // Decide legality of the mode / source / size combination.
    always_comb begin
        reserved     = (mode > 4'(AM_IMM_ZX));
        imm_mode     = (mode == 4'(AM_IMM_SX)) || (mode == 4'(AM_IMM_ZX));
        imm_store_ok = (mode == 4'(AM_IO8))   || (mode == 4'(AM_ABS8)) ||
                       (mode == 4'(AM_ABS12)) || (mode == 4'(AM_ABS16));
        illegal      = reserved
                     | (imm_mode & (is_write | imm_src))
                     | (imm_src & (~is_write | is_word | ~imm_store_ok));
        imm_load     = imm_mode;
    end

    // Extend an 8-bit immediate for a register load.
    always_comb begin
        if (mode == 4'(AM_IMM_SX))
            imm_val = {{DPAD{field[7]}}, field[7:0]};
        else
            imm_val = {{DPAD{1'b0}}, field[7:0]};
    end
endmodule

// File: rtl/eas_seq_ctrl.sv
// Bus sequencer: runs one aligned transfer or a split pair of byte
// transfers, assembles read data and counts the busy cycles.
// Assumes memory read data is valid in the same cycle as mem_req.
module eas_seq_ctrl
    import eas_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] ea,
    input  logic              illegal,
    input  logic              imm_load,
    input  logic [DATA_W-1:0] imm_val,
    input  logic              is_word,
    input  logic              is_write,
    input  logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic              err,
    output logic [CNT_W-1:0]  cycles,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int DPAD = DATA_W - BYTE_W;

    seq_st_e           st;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wd_q, rd_q;
    logic              we_q, word_q, err_q;
    logic [CNT_W-1:0]  cnt_q;

    // Step the state machine, capture requests and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            addr_q <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
            we_q   <= 1'b0;
            word_q <= 1'b0;
            err_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= ea;
                        wd_q   <= wdata;
                        we_q   <= is_write;
                        word_q <= is_word;
                        err_q  <= illegal;
                        cnt_q  <= CNT_W'(1);
                        rd_q   <= (imm_load && !illegal) ? imm_val : '0;
                        if (illegal || imm_load)
                            st <= ST_DONE;
                        else if (is_word && ea[0])
                            st <= ST_LO;
                        else
                            st <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (!we_q)
                        rd_q <= word_q ? mem_rdata
                                       : {{DPAD{1'b0}}, mem_rdata[BYTE_W-1:0]};
                    st <= ST_DONE;
                end
                ST_LO: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (!we_q)
                        rd_q[BYTE_W-1:0] <= mem_rdata[BYTE_W-1:0];
                    st <= ST_HI;
                end
                ST_HI: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (!we_q)
                        rd_q[DATA_W-1:BYTE_W] <= mem_rdata[BYTE_W-1:0];
                    st <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Drive the bus from the current state.
    always_comb begin
        mem_req   = (st == ST_XFER) || (st == ST_LO) || (st == ST_HI);
        mem_we    = mem_req && we_q;
        mem_word  = (st == ST_XFER) && word_q;
        mem_addr  = (st == ST_HI) ? addr_q + 1'b1 : addr_q;
        case (st)
            ST_XFER: mem_wdata = word_q ? wd_q : {{DPAD{1'b0}}, wd_q[BYTE_W-1:0]};
            ST_LO:   mem_wdata = {{DPAD{1'b0}}, wd_q[BYTE_W-1:0]};
            ST_HI:   mem_wdata = {{DPAD{1'b0}}, wd_q[DATA_W-1:BYTE_W]};
            default: mem_wdata = '0;
        endcase
    end

    // Completion outputs.
    assign done    = (st == ST_DONE);
    assign err     = done && err_q;
    assign cycles  = cnt_q;
    assign rd_data = rd_q;
endmodule

// File: rtl/addr_access_seq.sv
// Top of the effective-address and access sequencer: forms the address
// for the requested mode and hands it to the bus sequencer.
// Assumes requests are held stable in the cycle req_valid is high.
module addr_access_seq
    import eas_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter int                CNT_W   = 3,
    parameter logic [ADDR_W-1:0] IO_BASE = 'hFC00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_mode,
    input  logic [ADDR_W-1:0] req_field,
    input  logic [ADDR_W-1:0] areg_val,
    input  logic [ADDR_W-1:0] sp_val,
    input  logic              req_word,
    input  logic              req_write,
    input  logic              req_imm,
    input  logic [15:0]       req_wdata,
    output logic              done,
    output logic              err,
    output logic [CNT_W-1:0]  cycles,
    output logic [15:0]       rd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata
);
    logic [ADDR_W-1:0] ea;
    logic              illegal, imm_load;
    logic [DATA_W-1:0] imm_val;

    eas_ea_calc #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_ea (
        .mode     (req_mode),
        .field    (req_field),
        .areg     (areg_val),
        .sp       (sp_val),
        .is_word  (req_word),
        .is_write (req_write),
        .imm_src  (req_imm),
        .ea       (ea),
        .illegal  (illegal),
        .imm_load (imm_load),
        .imm_val  (imm_val)
    );

    eas_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ea        (ea),
        .illegal   (illegal),
        .imm_load  (imm_load),
        .imm_val   (imm_val),
        .is_word   (req_word),
        .is_write  (req_write),
        .wdata     (req_wdata),
        .done      (done),
        .err       (err),
        .cycles    (cycles),
        .rd_data   (rd_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_word  (mem_word),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );
endmodule

// File: rtl/eas_checker.sv
// Protocol checker for the access sequencer, watching its ports only.
// Assumes a synchronous active-low reset.
module eas_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              err,
    input logic [CNT_W-1:0]  cycles,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_word,
    input logic [ADDR_W-1:0] mem_addr
);
    // R6: a 16-bit transfer always lands on an even address.
    assert_word_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_word) |-> !mem_addr[0]);

    // R7: back-to-back transfers are byte transfers to adjacent addresses.
    assert_split_adjacent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (!mem_word && mem_addr == $past(mem_addr) + 1'b1));

    // R7: both halves of a split access go in the same direction.
    assert_split_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_we == $past(mem_we)));

    // R8: an illegal request finishes after one cycle.
    assert_err_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (cycles == CNT_W'(1)));

    // R8: err only appears together with done.
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R9: done is a single-cycle pulse.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: no transfer in the completion cycle.
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);
endmodule

bind addr_access_seq eas_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .err      (err),
    .cycles   (cycles),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_word (mem_word),
    .mem_addr (mem_addr)
);

// File: tb/addr_access_seq_bench.sv
// Self-checking bench: directed corners plus seeded random accesses.
module addr_access_seq_bench;
    localparam logic [15:0] IOB = 16'hFC00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_mode = '0;
    logic [15:0] req_field = '0, areg_val = '0, sp_val = '0, req_wdata = '0;
    logic        req_word = 1'b0, req_write = 1'b0, req_imm = 1'b0;
    logic        done, err, mem_req, mem_we, mem_word;
    logic [2:0]  cycles;
    logic [15:0] rd_data, mem_addr, mem_wdata, mem_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] t_addr  [4];
    logic [15:0] t_wdata [4];
    logic        t_we    [4];
    logic        t_word  [4];

    always #4 clk = ~clk;

    addr_access_seq #(.ADDR_W(16), .CNT_W(3), .IO_BASE(IOB)) u_addr_access_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_field(req_field), .areg_val(areg_val), .sp_val(sp_val),
        .req_word(req_word), .req_write(req_write), .req_imm(req_imm),
        .req_wdata(req_wdata), .done(done), .err(err), .cycles(cycles),
        .rd_data(rd_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Memory contents are a fixed function of the address.
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    always_comb begin
        if (mem_word) mem_rdata = {mem_byte(mem_addr + 16'd1), mem_byte(mem_addr)};
        else          mem_rdata = {8'h00, mem_byte(mem_addr)};
    end

    function automatic logic [15:0] ref_ea(input logic [3:0] m, input logic [15:0] f, ar, sp);
        logic [15:0] r;
        case (m)
            4'd0: r = ar;
            4'd1: r = ar + {{8{f[7]}}, f[7:0]};
            4'd2: r = ar + f;
            4'd3: r = sp + {12'h000, f[3:0]};
            4'd4: r = sp + {8'h00, f[7:0]};
            4'd5: r = sp + f;
            4'd6: r = IOB + {8'h00, f[7:0]};
            4'd7: r = {8'h00, f[7:0]};
            4'd8: r = {4'h0, f[11:0]};
            4'd9: r = f;
            default: r = 16'h0000;
        endcase
        return r;
    endfunction

    function automatic bit ref_illegal(input logic [3:0] m, input logic w, wr, im);
        if (m >= 4'd12) return 1'b1;
        if ((m == 4'd10 || m == 4'd11) && (wr || im)) return 1'b1;
        if (im && (!wr || w || m < 4'd6 || m > 4'd9)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string addr_req(input logic [3:0] m);
        if (m <= 4'd2) return "R1";
        if (m <= 4'd5) return "R2";
        if (m == 4'd6) return "R3";
        return "R4";
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] m, input logic [15:0] f, ar, sp,
                          input logic w, wr, im, input logic [15:0] wd, input bit noise);
        bit          ill, imm, odd, seen;
        logic [15:0] a, exp_rd;
        int          exp_n, exp_cyc, n, lat;
        string       crq;
        logic        got_err;
        logic [2:0]  got_cyc;
        logic [15:0] got_rd;
        ill = ref_illegal(m, w, wr, im);
        imm = !ill && (m == 4'd10 || m == 4'd11);
        a   = ref_ea(m, f, ar, sp);
        odd = !ill && !imm && w && a[0];
        exp_n   = (ill || imm) ? 0 : (odd ? 2 : 1);
        exp_cyc = (ill || imm) ? 1 : (odd ? 3 : 2);
        crq = ill ? "R8" : (imm ? "R5" : (odd ? "R7" : "R6"));
        if (imm)            exp_rd = (m == 4'd10) ? {{8{f[7]}}, f[7:0]} : {8'h00, f[7:0]};
        else if (ill || wr) exp_rd = 16'h0000;
        else if (w)         exp_rd = {mem_byte(a + 16'd1), mem_byte(a)};
        else                exp_rd = {8'h00, mem_byte(a)};

        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_field = f; areg_val = ar; sp_val = sp;
        req_word = w; req_write = wr; req_imm = im; req_wdata = wd;
        n = 0; seen = 0; lat = 0; got_err = 0; got_cyc = 0; got_rd = 0;
        for (int i = 1; i <= 8 && !seen; i++) begin
            @(negedge clk);
            if (mem_req && n < 4) begin
                t_addr[n] = mem_addr; t_wdata[n] = mem_wdata;
                t_we[n] = mem_we; t_word[n] = mem_word;
            end
            if (mem_req) n++;
            if (done) begin
                seen = 1; lat = i; got_err = err; got_cyc = cycles; got_rd = rd_data;
            end
            // R9: a request arriving while busy must be ignored.
            if (i == 1 && noise) begin
                req_valid = 1'b1; req_mode = 4'($urandom()); req_field = 16'($urandom());
                req_word = ~w; req_write = ~wr; req_wdata = ~wd;
            end else begin
                req_valid = 1'b0;
            end
        end
        chk(seen, "R9", "done seen", 32'(seen), 1);
        chk(lat == exp_cyc, crq, "done latency", 32'(lat), 32'(exp_cyc));
        chk(got_cyc == 3'(exp_cyc), crq, "cycle count", 32'(got_cyc), 32'(exp_cyc));
        chk(got_err == ill, "R8", "err flag", 32'(got_err), 32'(ill));
        chk(n == exp_n, crq, "transfer count", 32'(n), 32'(exp_n));
        if (n == exp_n && exp_n > 0) begin
            chk(t_addr[0] == a, addr_req(m), "address", 32'(t_addr[0]), 32'(a));
            chk(t_we[0] == wr, crq, "direction", 32'(t_we[0]), 32'(wr));
            chk(t_word[0] == (w && !odd), crq, "transfer size", 32'(t_word[0]), 32'(w && !odd));
            if (wr && !odd && w)
                chk(t_wdata[0] == wd, "R6", "word write data", 32'(t_wdata[0]), 32'(wd));
            if (wr && !w)
                chk(t_wdata[0][7:0] == wd[7:0], "R6", "byte write data",
                    32'(t_wdata[0][7:0]), 32'(wd[7:0]));
            if (odd) begin
                chk(t_addr[1] == a + 16'd1, "R7", "second address", 32'(t_addr[1]), 32'(a + 16'd1));
                chk(t_word[1] == 1'b0, "R7", "second size", 32'(t_word[1]), 0);
                if (wr) begin
                    chk(t_wdata[0][7:0] == wd[7:0], "R7", "low byte", 32'(t_wdata[0][7:0]), 32'(wd[7:0]));
                    chk(t_wdata[1][7:0] == wd[15:8], "R7", "high byte", 32'(t_wdata[1][7:0]), 32'(wd[15:8]));
                end
            end
        end
        chk(got_rd == exp_rd, imm ? "R5" : "R10", "result", 32'(got_rd), 32'(exp_rd));
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk(!done && !mem_req, "R9", "quiet after done", 32'({done, mem_req}), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R10: reset state.
        chk(!done && !err && !mem_req, "R10", "reset outputs", 32'({done, err, mem_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 directed
        run_op(4'd0, 16'h0000, 16'h1234, 16'h0, 0, 0, 0, 16'h0, 0);
        run_op(4'd1, 16'hFF80, 16'h1000, 16'h0, 0, 0, 0, 16'h0, 0);
        run_op(4'd1, 16'h007F, 16'h1000, 16'h0, 0, 1, 0, 16'h00C3, 1);
        run_op(4'd2, 16'h8000, 16'h9000, 16'h0, 1, 0, 0, 16'h0, 0);
        // R2 directed
        run_op(4'd3, 16'hFFFF, 16'h0, 16'h2000, 0, 0, 0, 16'h0, 0);
        run_op(4'd4, 16'h0080, 16'h0, 16'h2000, 1, 0, 0, 16'h0, 0);
        run_op(4'd5, 16'hF000, 16'h0, 16'h2001, 1, 1, 0, 16'hBEEF, 1);
        // R3 directed
        run_op(4'd6, 16'h12FF, 16'h0, 16'h0, 0, 0, 0, 16'h0, 0);
        // R4 directed
        run_op(4'd7, 16'h12AB, 16'h0, 16'h0, 0, 0, 0, 16'h0, 0);
        run_op(4'd8, 16'hF123, 16'h0, 16'h0, 1, 0, 0, 16'h0, 0);
        run_op(4'd9, 16'hFFFF, 16'h0, 16'h0, 1, 0, 0, 16'h0, 1);
        run_op(4'd9, 16'hFFFF, 16'h0, 16'h0, 1, 1, 0, 16'h5AA5, 0);
        // R5 directed
        run_op(4'd10, 16'h0080, 16'h0, 16'h0, 1, 0, 0, 16'h0, 0);
        run_op(4'd11, 16'h0080, 16'h0, 16'h0, 1, 0, 0, 16'h0, 1);
        // R8 directed
        run_op(4'd1, 16'h0004, 16'h0100, 16'h0, 0, 1, 1, 16'h0011, 1);
        run_op(4'd6, 16'h0010, 16'h0, 16'h0, 0, 1, 1, 16'h0022, 0);
        run_op(4'd7, 16'h0010, 16'h0, 16'h0, 1, 1, 1, 16'h0033, 0);
        run_op(4'd13, 16'h0010, 16'h0, 16'h0, 0, 0, 0, 16'h0, 0);
        run_op(4'd10, 16'h0010, 16'h0, 16'h0, 0, 1, 0, 16'h0, 0);
        // Random mix
        for (int r = 0; r < 400; r++) begin
            run_op(4'($urandom()), 16'($urandom()), 16'($urandom()), 16'($urandom()),
                   1'($urandom()), 1'($urandom()), ($urandom() % 6) == 0,
                   16'($urandom()), 1'($urandom()));
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule